// File: doc/BRIEF.md
# Dispatch-Gated Instruction Scheduler

This block sits between a dispatch stage and the execution pipelines. Before each instruction is handed over, the block drives a stall code for the instruction on offer. The dispatch stage may assert `disp_vld` only while that code reads "open". An accepted instruction takes one entry of the shared scheduler buffer. A memory operation also makes the block pulse an allocation request towards the load/store unit.

An accepted instruction whose operands are ready, and whose memory ordering is cleared where it applies, is ready at once. Otherwise it waits in the buffer until tag-matched wake-up pulses arrive. One wake-up covers operands and one covers load/store ordering. Every cycle, all waiting entries whose conditions are now met move to the ready state together. The oldest ready entry is then issued, with age judged by modular comparison of sequence tags.

A ready instruction marked zero-latency, or marked as bound to an in-order zero-depth resource, never enters the ready state. It leaves on the issue port in the following cycle and has priority over the pool. Completion reports for memory operations are passed on to the load/store unit so that it can free the queue slot.

Top module: `disp_sched`

## Requirements
- R1: `disp_status` is combinational and uses these codes: 0 open, 1 load queue full, 2 store queue full, 3 scheduler buffer full, 4 dispatch group hold.
- R2: Buffer-full takes precedence over group hold. Either of these takes precedence over any load/store queue condition. Load-queue-full takes precedence over store-queue-full.
- R3: `lsu_lq_full` affects the code only for an instruction with `disp_load` set. `lsu_sq_full` affects it only for one with `disp_store` set. Neither affects other instructions.
- R4: An accepted instruction that is not bypassed raises `buf_used` by one at the accepting edge. While `buf_used` equals DEPTH, the code is 3 for any instruction.
- R5: Accepting an instruction with `disp_load` or `disp_store` set pulses `lsu_alloc_ld` or `lsu_alloc_st` (or both) for one cycle, in the cycle after acceptance.
- R6: An accepted instruction that is ready and has `disp_zero_lat` or `disp_inorder` set appears in the next cycle with `iss_vld` = 1 and `iss_bypass` = 1. It leaves `buf_used` unchanged.
- R7: A waiting instruction needs an operand wake on its tag. A memory operation also needs an ordering wake, unless `lsu_ord_ok` was high at dispatch. It becomes ready at the edge where the last condition is met and is issued no earlier than the following edge.
- R8: Among ready entries, the one with the oldest tag issues first. Tag a is older than tag b when bit TAG_W-1 of (a - b) mod 2^TAG_W is set, so the comparison survives wrap.
- R9: At most one instruction issues per edge, and a bypass takes priority over the pool. An issue from the pool shows `iss_bypass` = 0 one cycle later and lowers `buf_used` by one.
- R10: `cpl_vld` with `cpl_mem` set produces `lsu_free_vld` with the same tag one cycle later. A completion without `cpl_mem` produces none.
- R11: `disp_vld` is asserted only while `disp_status` is 0. A dispatch offered in any other state is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_vld | input | 1 | Dispatch stage presents an instruction |
| disp_tag | input | TAG_W | Sequence tag of the offered instruction |
| disp_zero_lat | input | 1 | Instruction has zero latency |
| disp_inorder | input | 1 | Instruction is bound to an in-order zero-depth resource |
| disp_load | input | 1 | Instruction reads memory |
| disp_store | input | 1 | Instruction writes memory |
| disp_ops_rdy | input | 1 | Operands already available |
| disp_grp_hold | input | 1 | Dispatch group must stall |
| lsu_lq_full | input | 1 | Load queue has no free slot |
| lsu_sq_full | input | 1 | Store queue has no free slot |
| lsu_ord_ok | input | 1 | Ordering check clears the offered memory operation |
| opnd_wake_vld | input | 1 | Operand wake-up valid |
| opnd_wake_tag | input | TAG_W | Tag whose operands became ready |
| mem_wake_vld | input | 1 | Ordering wake-up valid |
| mem_wake_tag | input | TAG_W | Tag whose memory ordering cleared |
| cpl_vld | input | 1 | Execution completion report |
| cpl_tag | input | TAG_W | Tag of the completed instruction |
| cpl_mem | input | 1 | Completed instruction was a memory operation |
| disp_status | output | 3 | Stall code for the offered instruction |
| iss_vld | output | 1 | Instruction issued |
| iss_tag | output | TAG_W | Tag of the issued instruction |
| iss_bypass | output | 1 | Issue came straight from dispatch |
| lsu_alloc_ld | output | 1 | Allocate a load queue slot |
| lsu_alloc_st | output | 1 | Allocate a store queue slot |
| lsu_free_vld | output | 1 | Free the queue slot of a completed memory operation |
| lsu_free_tag | output | TAG_W | Tag whose slot is freed |
| buf_used | output | $clog2(DEPTH+1) | Scheduler buffer entries held |

## Verification
The stall code has no register in its path, so the bench reads it one nanosecond after driving the offered instruction, within the same cycle. Bypass issues, load/store allocation pulses and completion forwarding show up one edge after the cause. A pool entry has two stages on its way out: a wake driven before edge n makes it ready at edge n, and it issues at edge n+1. The bench checks for that entry at the falling edge after n+1 and checks at the falling edge after n that it has not issued yet. All inputs change and all outputs are sampled on falling edges, so every expected value lines up with a whole number of rising edges.

// File: rtl/dsched_pkg.sv
package dsched_pkg;

  typedef enum logic [2:0] {
    ST_OPEN       = 3'd0,
    ST_LDQ_FULL   = 3'd1,
    ST_STQ_FULL   = 3'd2,
    ST_BUF_FULL   = 3'd3,
    ST_GROUP_HOLD = 3'd4
  } stall_e;

  // Priority: buffer, group hold, then load queue, then store queue.
  function automatic stall_e stall_code(input logic full, input logic hold,
                                        input logic ld, input logic st,
                                        input logic lqf, input logic sqf);
    if (full)       return ST_BUF_FULL;
    if (hold)       return ST_GROUP_HOLD;
    if (ld && lqf)  return ST_LDQ_FULL;
    if (st && sqf)  return ST_STQ_FULL;
    return ST_OPEN;
  endfunction

endpackage

// File: rtl/dsched_gate.sv
module dsched_gate #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] used,
  input  logic             hold,
  input  logic             is_ld,
  input  logic             is_st,
  input  logic             lq_full,
  input  logic             sq_full,
  output logic [2:0]       status
);
  import dsched_pkg::*;

  logic full;
  assign full   = (used == CNT_W'(DEPTH));
  assign status = stall_code(full, hold, is_ld, is_st, lq_full, sq_full);
endmodule

// File: rtl/dsched_pick.sv
module dsched_pick #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]       cand,
  input  logic [DEPTH*TAG_W-1:0] tags_flat,
  output logic                   any,
  output logic [IDX_W-1:0]       idx
);
  // a older than b when the modular difference is negative
  function automatic logic is_older(input logic [TAG_W-1:0] a,
                                    input logic [TAG_W-1:0] b);
    logic [TAG_W-1:0] d;
    d = a - b;
    return d[TAG_W-1];
  endfunction

  logic [TAG_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i] && (!any || is_older(tags_flat[i*TAG_W +: TAG_W], best))) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        best = tags_flat[i*TAG_W +: TAG_W];
      end
    end
  end
endmodule

// File: rtl/dsched_pool.sv
module dsched_pool #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [TAG_W-1:0]       wr_tag,
  input  logic                   wr_ops,
  input  logic                   wr_mok,
  input  logic                   ow_vld,
  input  logic [TAG_W-1:0]       ow_tag,
  input  logic                   mw_vld,
  input  logic [TAG_W-1:0]       mw_tag,
  input  logic                   pop_en,
  input  logic [IDX_W-1:0]       pop_idx,
  output logic [DEPTH-1:0]       ready_vec,
  output logic [DEPTH*TAG_W-1:0] tags_flat,
  output logic [CNT_W-1:0]       used
);
  logic [DEPTH-1:0] vld_q, rdy_q, ops_q, mok_q;
  logic [DEPTH-1:0] ops_nx, mok_nx, promote;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [IDX_W-1:0] free_idx;
  logic             found;

  // Wake-up match and promotion scan over every waiting entry.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ops_nx[i]  = ops_q[i] | (ow_vld && (tag_q[i] == ow_tag));
      mok_nx[i]  = mok_q[i] | (mw_vld && (tag_q[i] == mw_tag));
      promote[i] = vld_q[i] & ~rdy_q[i] & ops_nx[i] & mok_nx[i];
    end
  end

  always_comb begin
    free_idx = '0;
    found    = 1'b0;
    used     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      used = used + CNT_W'(vld_q[i]);
      if (!vld_q[i] && !found) begin
        free_idx = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rdy_q <= '0;
      ops_q <= '0;
      mok_q <= '0;
      for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pop_en && pop_idx == IDX_W'(i)) begin
          vld_q[i] <= 1'b0;
          rdy_q[i] <= 1'b0;
        end else if (wr_en && found && free_idx == IDX_W'(i)) begin
          vld_q[i] <= 1'b1;
          tag_q[i] <= wr_tag;
          ops_q[i] <= wr_ops;
          mok_q[i] <= wr_mok;
          rdy_q[i] <= wr_ops & wr_mok;
        end else if (vld_q[i]) begin
          ops_q[i] <= ops_nx[i];
          mok_q[i] <= mok_nx[i];
          if (promote[i]) rdy_q[i] <= 1'b1;
        end
      end
    end
  end

  assign ready_vec = rdy_q & vld_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tags
    assign tags_flat[g*TAG_W +: TAG_W] = tag_q[g];
  end
endmodule

// File: rtl/disp_sched.sv
module disp_sched #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       disp_vld,
  input  logic [TAG_W-1:0]           disp_tag,
  input  logic                       disp_zero_lat,
  input  logic                       disp_inorder,
  input  logic                       disp_load,
  input  logic                       disp_store,
  input  logic                       disp_ops_rdy,
  input  logic                       disp_grp_hold,
  input  logic                       lsu_lq_full,
  input  logic                       lsu_sq_full,
  input  logic                       lsu_ord_ok,
  input  logic                       opnd_wake_vld,
  input  logic [TAG_W-1:0]           opnd_wake_tag,
  input  logic                       mem_wake_vld,
  input  logic [TAG_W-1:0]           mem_wake_tag,
  input  logic                       cpl_vld,
  input  logic [TAG_W-1:0]           cpl_tag,
  input  logic                       cpl_mem,
  output logic [2:0]                 disp_status,
  output logic                       iss_vld,
  output logic [TAG_W-1:0]           iss_tag,
  output logic                       iss_bypass,
  output logic                       lsu_alloc_ld,
  output logic                       lsu_alloc_st,
  output logic                       lsu_free_vld,
  output logic [TAG_W-1:0]           lsu_free_tag,
  output logic [$clog2(DEPTH+1)-1:0] buf_used
);
  import dsched_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [2:0]             stat;
  logic                   is_mem, disp_ready, accept, bypass_now, wr_en, pop_en;
  logic [DEPTH-1:0]       ready_vec;
  logic [DEPTH*TAG_W-1:0] tags_flat;
  logic [CNT_W-1:0]       used;
  logic                   pick_any;
  logic [IDX_W-1:0]       pick_idx;
  logic [TAG_W-1:0]       pick_tag;

  dsched_gate #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_gate (
    .used(used), .hold(disp_grp_hold), .is_ld(disp_load), .is_st(disp_store),
    .lq_full(lsu_lq_full), .sq_full(lsu_sq_full), .status(stat)
  );

  assign is_mem     = disp_load | disp_store;
  assign accept     = disp_vld && (stat == ST_OPEN);
  assign disp_ready = disp_ops_rdy & (~is_mem | lsu_ord_ok);
  assign bypass_now = accept & disp_ready & (disp_zero_lat | disp_inorder);
  assign wr_en      = accept & ~bypass_now;

  dsched_pool #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_tag(disp_tag), .wr_ops(disp_ops_rdy),
    .wr_mok(~is_mem | lsu_ord_ok),
    .ow_vld(opnd_wake_vld), .ow_tag(opnd_wake_tag),
    .mw_vld(mem_wake_vld), .mw_tag(mem_wake_tag),
    .pop_en(pop_en), .pop_idx(pick_idx),
    .ready_vec(ready_vec), .tags_flat(tags_flat), .used(used)
  );

  dsched_pick #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_pick (
    .cand(ready_vec), .tags_flat(tags_flat), .any(pick_any), .idx(pick_idx)
  );

  assign pick_tag = tags_flat[pick_idx*TAG_W +: TAG_W];
  assign pop_en   = pick_any & ~bypass_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_vld      <= 1'b0;
      iss_tag      <= '0;
      iss_bypass   <= 1'b0;
      lsu_alloc_ld <= 1'b0;
      lsu_alloc_st <= 1'b0;
      lsu_free_vld <= 1'b0;
      lsu_free_tag <= '0;
    end else begin
      iss_vld      <= bypass_now | pop_en;
      iss_tag      <= bypass_now ? disp_tag : pick_tag;
      iss_bypass   <= bypass_now;
      lsu_alloc_ld <= accept & disp_load;
      lsu_alloc_st <= accept & disp_store;
      lsu_free_vld <= cpl_vld & cpl_mem;
      lsu_free_tag <= cpl_tag;
    end
  end

  assign disp_status = stat;
  assign buf_used    = used;
endmodule

// File: rtl/dsched_chk.sv
module dsched_chk #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_vld,
  input logic [TAG_W-1:0] disp_tag,
  input logic             disp_grp_hold,
  input logic [2:0]       disp_status,
  input logic             cpl_vld,
  input logic             cpl_mem,
  input logic [TAG_W-1:0] cpl_tag,
  input logic             iss_vld,
  input logic             iss_bypass,
  input logic [TAG_W-1:0] iss_tag,
  input logic             lsu_free_vld,
  input logic [TAG_W-1:0] lsu_free_tag,
  input logic [CNT_W-1:0] buf_used,
  input logic             bypass_now,
  input logic             wr_en,
  input logic             pop_en
);
  a_r11_no_stalled_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    disp_vld |-> disp_status == 3'd0);

  a_r4_buf_bound: assert property (@(posedge clk) disable iff (!rst_n)
    buf_used <= CNT_W'(DEPTH));

  a_r4_full_code: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_used == CNT_W'(DEPTH)) |-> disp_status == 3'd3);

  a_r2_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_used != CNT_W'(DEPTH) && disp_grp_hold) |-> disp_status == 3'd4);

  a_r9_buf_track: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(buf_used) == int'($past(buf_used)) + int'($past(wr_en)) - int'($past(pop_en)));

  a_r6_bypass_out: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_now |=> iss_vld && iss_bypass && iss_tag == $past(disp_tag));

  a_r9_pool_out: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |=> iss_vld && !iss_bypass);

  a_r10_free_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_vld && cpl_mem) |=> lsu_free_vld && lsu_free_tag == $past(cpl_tag));
endmodule

bind disp_sched dsched_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_vld(disp_vld), .disp_tag(disp_tag),
  .disp_grp_hold(disp_grp_hold), .disp_status(disp_status),
  .cpl_vld(cpl_vld), .cpl_mem(cpl_mem), .cpl_tag(cpl_tag),
  .iss_vld(iss_vld), .iss_bypass(iss_bypass), .iss_tag(iss_tag),
  .lsu_free_vld(lsu_free_vld), .lsu_free_tag(lsu_free_tag),
  .buf_used(buf_used), .bypass_now(bypass_now), .wr_en(wr_en), .pop_en(pop_en)
);

// File: tb/disp_sched_tb_top.sv
module disp_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int TAG_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_vld, disp_zero_lat, disp_inorder, disp_load, disp_store, disp_ops_rdy;
  logic disp_grp_hold, lsu_lq_full, lsu_sq_full, lsu_ord_ok;
  logic opnd_wake_vld, mem_wake_vld, cpl_vld, cpl_mem;
  logic [TAG_W-1:0] disp_tag, opnd_wake_tag, mem_wake_tag, cpl_tag;
  logic [2:0] disp_status;
  logic iss_vld, iss_bypass, lsu_alloc_ld, lsu_alloc_st, lsu_free_vld;
  logic [TAG_W-1:0] iss_tag, lsu_free_tag;
  logic [3:0] buf_used;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_sched #(.DEPTH(DEPTH), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .disp_vld(disp_vld), .disp_tag(disp_tag),
    .disp_zero_lat(disp_zero_lat), .disp_inorder(disp_inorder),
    .disp_load(disp_load), .disp_store(disp_store), .disp_ops_rdy(disp_ops_rdy),
    .disp_grp_hold(disp_grp_hold), .lsu_lq_full(lsu_lq_full),
    .lsu_sq_full(lsu_sq_full), .lsu_ord_ok(lsu_ord_ok),
    .opnd_wake_vld(opnd_wake_vld), .opnd_wake_tag(opnd_wake_tag),
    .mem_wake_vld(mem_wake_vld), .mem_wake_tag(mem_wake_tag),
    .cpl_vld(cpl_vld), .cpl_tag(cpl_tag), .cpl_mem(cpl_mem),
    .disp_status(disp_status), .iss_vld(iss_vld), .iss_tag(iss_tag),
    .iss_bypass(iss_bypass), .lsu_alloc_ld(lsu_alloc_ld),
    .lsu_alloc_st(lsu_alloc_st), .lsu_free_vld(lsu_free_vld),
    .lsu_free_tag(lsu_free_tag), .buf_used(buf_used)
  );

  task automatic check(input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int exp_code(input bit full, input bit hold, input bit ld,
                                  input bit st, input bit lqf, input bit sqf);
    if (full) return 3;
    if (hold) return 4;
    if (ld && lqf) return 1;
    if (st && sqf) return 2;
    return 0;
  endfunction

  task automatic idle();
    disp_vld = 0; disp_zero_lat = 0; disp_inorder = 0; disp_load = 0;
    disp_store = 0; disp_ops_rdy = 0; disp_grp_hold = 0; lsu_lq_full = 0;
    lsu_sq_full = 0; lsu_ord_ok = 0; opnd_wake_vld = 0; mem_wake_vld = 0;
    cpl_vld = 0; cpl_mem = 0;
  endtask

  task automatic put(input int tag, input bit zl, input bit io, input bit ld,
                     input bit st, input bit ops, input bit ord);
    disp_tag = TAG_W'(tag); disp_zero_lat = zl; disp_inorder = io;
    disp_load = ld; disp_store = st; disp_ops_rdy = ops; lsu_ord_ok = ord;
    #1;
    check(int'(disp_status), 0, "R11 status open before dispatch");
    disp_vld = 1;
  endtask

  task automatic sweep(input bit full, input string what);
    for (int c = 0; c < 32; c++) begin
      {disp_grp_hold, disp_load, disp_store, lsu_lq_full, lsu_sq_full} = 5'(c);
      #1;
      check(int'(disp_status),
            exp_code(full, c[4], c[3], c[2], c[1], c[0]), what);
    end
    idle();
  endtask

  task automatic expect_iss(input int tag, input bit byp, input int used, input string what);
    check(int'(iss_vld), 1, what);
    check(int'(iss_tag), tag, what);
    check(int'(iss_bypass), int'(byp), what);
    check(int'(buf_used), used, what);
  endtask

  initial begin
    int wake_ord [7] = '{1, 63, 2, 61, 0, 62, 60};
    int drain [7] = '{60, 61, 62, 63, 0, 1, 2};
    idle();
    disp_tag = '0; opnd_wake_tag = '0; mem_wake_tag = '0; cpl_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(int'(iss_vld), 0, "R9 reset no issue");
    check(int'(buf_used), 0, "R4 reset buffer empty");
    check(int'(disp_status), 0, "R1 reset status open");
    check(int'(lsu_alloc_ld | lsu_alloc_st), 0, "R5 reset no alloc");
    check(int'(lsu_free_vld), 0, "R10 reset no free");

    sweep(1'b0, "R1 R2 R3 status code, buffer not full");

    // R6 bypass on zero latency, in-order resource, and ordered load
    @(negedge clk); put(1, 1, 0, 0, 0, 1, 0);
    @(negedge clk); idle(); expect_iss(1, 1, 0, "R6 zero-latency bypass");
    put(2, 0, 1, 0, 0, 1, 0);
    @(negedge clk); idle(); expect_iss(2, 1, 0, "R6 in-order bypass");
    put(3, 1, 0, 1, 0, 1, 1);
    @(negedge clk); idle(); expect_iss(3, 1, 0, "R6 ordered load bypass");
    check(int'(lsu_alloc_ld), 1, "R5 load alloc pulse");
    check(int'(lsu_alloc_st), 0, "R5 no store alloc for load");
    @(negedge clk);
    check(int'(iss_vld), 0, "R9 issue is a single pulse");
    check(int'(lsu_alloc_ld), 0, "R5 alloc is a single pulse");

    // R7 zero-latency instruction not ready waits in the buffer
    put(4, 1, 0, 0, 0, 0, 0);
    @(negedge clk); idle();
    check(int'(iss_vld), 0, "R7 unready zero-latency waits");
    check(int'(buf_used), 1, "R4 entry reserved");
    opnd_wake_vld = 1; opnd_wake_tag = 4;
    @(negedge clk); idle();
    check(int'(iss_vld), 0, "R7 not issued at promoting edge");
    @(negedge clk);
    expect_iss(4, 0, 0, "R7 R9 issued from pool after wake");

    // R7 store needs ordering wake even with operands ready
    put(5, 0, 0, 0, 1, 1, 0);
    @(negedge clk); idle();
    check(int'(lsu_alloc_st), 1, "R5 store alloc pulse");
    check(int'(lsu_alloc_ld), 0, "R5 no load alloc for store");
    opnd_wake_vld = 1; opnd_wake_tag = 5;
    @(negedge clk); idle();
    @(negedge clk);
    check(int'(iss_vld), 0, "R7 operand wake alone insufficient");
    mem_wake_vld = 1; mem_wake_tag = 5;
    @(negedge clk); idle();
    @(negedge clk);
    expect_iss(5, 0, 0, "R7 store issued after ordering wake");

    // R7 load with both conditions pending, ordering first
    put(6, 1, 0, 1, 0, 0, 0);
    @(negedge clk); idle();
    mem_wake_vld = 1; mem_wake_tag = 6;
    @(negedge clk); idle();
    @(negedge clk);
    check(int'(iss_vld), 0, "R7 ordering wake alone insufficient");
    opnd_wake_vld = 1; opnd_wake_tag = 6;
    @(negedge clk); idle();
    @(negedge clk);
    expect_iss(6, 0, 0, "R7 load issued after both wakes");

    // R10 completion forwarding
    cpl_vld = 1; cpl_mem = 1; cpl_tag = 5;
    @(negedge clk); idle();
    check(int'(lsu_free_vld), 1, "R10 memory completion frees slot");
    check(int'(lsu_free_tag), 5, "R10 freed tag");
    cpl_vld = 1; cpl_mem = 0; cpl_tag = 7;
    @(negedge clk); idle();
    check(int'(lsu_free_vld), 0, "R10 non-memory completion ignored");

    // R4 fill buffer with tags crossing wrap
    for (int k = 0; k < DEPTH; k++) begin
      put((60 + k) % 64, 0, 0, 0, 0, 0, 0);
      @(negedge clk); idle();
    end
    check(int'(buf_used), DEPTH, "R4 buffer holds DEPTH entries");
    sweep(1'b1, "R2 R4 full buffer overrides all");

    @(negedge clk);
    opnd_wake_vld = 1; opnd_wake_tag = 3;
    @(negedge clk); idle();
    @(negedge clk);
    expect_iss(3, 0, 7, "R9 newest woken issues alone");

    // R9 bypass holds the port while pool entries become ready
    for (int j = 0; j < 7; j++) begin
      put(4 + j, 1, 0, 0, 0, 1, 0);
      opnd_wake_vld = 1; opnd_wake_tag = TAG_W'(wake_ord[j]);
      @(negedge clk); idle();
      expect_iss(4 + j, 1, 7, "R9 bypass priority over pool");
    end

    // R8 drain oldest first across wrap
    for (int j = 0; j < 7; j++) begin
      @(negedge clk);
      expect_iss(drain[j], 0, 6 - j, "R8 oldest tag first");
    end
    @(negedge clk);
    check(int'(iss_vld), 0, "R9 pool drained");
    check(int'(buf_used), 0, "R4 buffer released");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule